// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the six base address registers of one PCI function's configuration header and decodes incoming transaction addresses against them. The kind of each slot is fixed at elaboration: 32-bit memory window, 32-bit I/O window, lower or upper half of a 64-bit memory window, or unused. Region size, the prefetchable flag, the number of writable upper bits of a 64-bit window, and an optional fixed base address are also set per slot.

Configuration software reaches the registers through a port that takes a slot index, a 32-bit data word and byte enables. Sizing works the usual way: software writes all ones, reads back, and finds the size from the lowest writable bit. Reads are combinational, and a write takes effect at the next clock edge. The address side takes a 64-bit transaction address and a flag that marks I/O space, and it drives one hit line per slot.

Top module: `pci_bar_bank`

## Requirements
- R1: After reset every writable base bit is zero. Every slot then reads back only its type bits, an unused slot reads 0, and slot indices 6 and 7 read 0.
- R2: A memory slot reads bit 0 as 0. Its bits 2..1 read as 00 for a 32-bit window or 10 for the lower half of a 64-bit window, and its bit 3 reads as the prefetchable setting. None of these bits can be written.
- R3: An I/O slot reads bit 0 as 1 and bit 1 as 0. Its region size is clamped to between 4 and 256 bytes.
- R4: For a region of 2^S bytes, only base bits at position S and above can be written. Bits below S (other than the type bits) read 0, so writing all ones and reading back reveals S.
- R5: On a write, byte k (bits 8k+7..8k) changes only when cfg_be[k] is 1.
- R6: The upper half of a 64-bit pair with N decoded bits accepts writes to bits N-1..0 and reads 0 above them. Its own hit line stays 0, and a hit on the pair is reported on the lower half's line.
- R7: A 32-bit memory slot hits only when the access is in memory space, address bits 63..32 are zero, and address bits S..31 equal the stored base.
- R8: An I/O slot hits only when the access is in I/O space, address bits 63..32 are zero, and address bits S..31 equal the stored base.
- R9: A 64-bit pair hits only in memory space, and only when both the lower word above S and the whole upper word equal the stored pair.
- R10: A slot with a fixed base claims accesses at that base from reset onward. Writes to it complete but change nothing, and reads always return the fixed base together with the type bits.
- R11: An unused slot reads 0 and never hits.
- R12: A slot's value changes only on a clock edge where cfg_wr is 1 and cfg_idx selects that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 3 | Slot index for both reads and writes |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the slot selected by cfg_idx (combinational) |
| txn_addr | input | 64 | Transaction address |
| txn_io | input | 1 | 1 for I/O space, 0 for memory space |
| bar_hit | output | 6 | One hit line per slot |

## Verification
The bench overrides the defaults and builds one configuration that uses every kind at once:
- slot 0: 4 KB 32-bit memory window
- slots 1 and 2: a 1 MB prefetchable 64-bit pair, with 8 decoded upper bits
- slot 3: 32-byte I/O window
- slot 4: 64 KB memory window with a fixed base of C0DE0000h
- slot 5: unused

With this mix, sizing readback, masking of the upper half, the I/O marker, writes ignored on the fixed slot and the never-hit unused slot can all be exercised in one run. It also places addresses just inside and just outside each window, including accesses that differ only in upper-word bits.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_MEM32 = 3'd1,
    BK_IO    = 3'd2,
    BK_M64LO = 3'd3,
    BK_M64HI = 3'd4
  } bar_kind_e;

  // All-ones above bit lg of a 64-bit address.
  function automatic logic [63:0] size_mask(int unsigned lg);
    return {64{1'b1}} << lg;
  endfunction

  function automatic int unsigned clamp_size(bar_kind_e k, int unsigned lg);
    int unsigned lo, hi;
    case (k)
      BK_IO:    begin lo = 2; hi = 8;  end
      BK_MEM32: begin lo = 4; hi = 31; end
      default:  begin lo = 4; hi = 63; end
    endcase
    if (lg < lo) return lo;
    if (lg > hi) return hi;
    return lg;
  endfunction

  function automatic logic [31:0] upper_keep(int unsigned n);
    if (n >= 32) return {32{1'b1}};
    return (32'h1 << n) - 32'h1;
  endfunction

  // A half of a 64-bit pair without its partner is treated as unused.
  function automatic bar_kind_e eff_kind(logic [2:0] raw, logic [2:0] prev, logic [2:0] next);
    case (raw)
      3'd1:    return BK_MEM32;
      3'd2:    return BK_IO;
      3'd3:    return (next == 3'd4) ? BK_M64LO : BK_NONE;
      3'd4:    return (prev == 3'd3) ? BK_M64HI : BK_NONE;
      default: return BK_NONE;
    endcase
  endfunction

  // Writable bits of a slot; for the upper half lg is the pair's size.
  function automatic logic [31:0] wr_mask(bar_kind_e k, int unsigned lg, int unsigned n);
    logic [63:0] t;
    case (k)
      BK_MEM32, BK_IO, BK_M64LO: begin
        t = size_mask(clamp_size(k, lg));
        return t[31:0];
      end
      BK_M64HI: begin
        t = size_mask(clamp_size(BK_M64LO, lg));
        return t[63:32] & upper_keep(n);
      end
      default: return 32'h0;
    endcase
  endfunction

  // Upper-word compare mask of a 64-bit pair.
  function automatic logic [31:0] hi_cmp_mask(int unsigned lg);
    logic [63:0] t;
    t = size_mask(clamp_size(BK_M64LO, lg));
    return t[63:32];
  endfunction

  function automatic logic [31:0] type_bits(bar_kind_e k, logic pref);
    case (k)
      BK_MEM32: return {28'h0, pref, 3'b000};
      BK_M64LO: return {28'h0, pref, 3'b100};
      BK_IO:    return 32'h1;
      default:  return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bar_reg.sv
module bar_reg #(
  parameter logic [31:0] WMASK    = 32'h0,
  parameter logic [31:0] TBITS    = 32'h0,
  parameter bit          FIXED    = 1'b0,
  parameter logic [31:0] FIX_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] base,
  output logic [31:0] word
);
  logic [31:0] stored;
  logic [31:0] be_bits;
  logic [31:0] upd;

  always_comb begin
    for (int b = 0; b < 4; b++) be_bits[b*8 +: 8] = {8{be[b]}};
    upd = WMASK & be_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stored <= 32'h0;
    else if (wr_en) stored <= (stored & ~upd) | (wdata & upd);
  end

  assign base = FIXED ? (FIX_BASE & WMASK) : stored;
  assign word = base | TBITS;
endmodule

// File: rtl/bar_match.sv
module bar_match
  import bar_pkg::*;
#(
  parameter bar_kind_e   KIND   = BK_NONE,
  parameter logic [31:0] LO_CMP = 32'h0,
  parameter logic [31:0] HI_CMP = 32'h0
) (
  input  logic [63:0] addr,
  input  logic        is_io,
  input  logic [31:0] base_lo,
  input  logic [31:0] base_hi,
  output logic        hit
);
  logic space_ok, lo_ok, hi_ok;

  always_comb begin
    space_ok = (KIND == BK_IO) ? is_io : !is_io;
    lo_ok    = (addr[31:0] & LO_CMP) == (base_lo & LO_CMP);
    if (KIND == BK_M64LO) hi_ok = (addr[63:32] & HI_CMP) == (base_hi & HI_CMP);
    else                  hi_ok = (addr[63:32] == 32'h0);
    case (KIND)
      BK_MEM32, BK_IO, BK_M64LO: hit = space_ok && lo_ok && hi_ok;
      default:                   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_bar_bank.sv
module pci_bar_bank
  import bar_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter logic [NUM_BARS*3-1:0]  KIND_CFG = {{(NUM_BARS-1){3'd0}}, 3'd1},
  parameter logic [NUM_BARS*6-1:0]  SIZE_CFG = {NUM_BARS{6'd12}},
  parameter logic [NUM_BARS*6-1:0]  HIBITS_CFG = {NUM_BARS{6'd32}},
  parameter logic [NUM_BARS-1:0]    PREF_CFG = '0,
  parameter logic [NUM_BARS-1:0]    FIX_CFG  = '0,
  parameter logic [NUM_BARS*32-1:0] FIX_BASE_CFG = '0,
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [63:0]      txn_addr,
  input  logic             txn_io,
  output logic [NUM_BARS-1:0] bar_hit
);
  // Named internal events for the checker.
  logic [NUM_BARS-1:0]    bar_wr;
  logic [31:0]            bar_word [NUM_BARS];
  logic [31:0]            bar_base [NUM_BARS+1];
  logic [NUM_BARS*32-1:0] bar_word_flat;

  assign bar_base[NUM_BARS] = 32'h0;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    localparam int unsigned PI = (i > 0) ? i - 1 : 0;
    localparam int unsigned NI = (i + 1 < NUM_BARS) ? i + 1 : i;
    localparam logic [2:0] RAW  = KIND_CFG[i*3 +: 3];
    localparam logic [2:0] PREV = (i > 0) ? KIND_CFG[PI*3 +: 3] : 3'd0;
    localparam logic [2:0] NEXT = (i + 1 < NUM_BARS) ? KIND_CFG[NI*3 +: 3] : 3'd0;
    localparam bar_kind_e  KIND = eff_kind(RAW, PREV, NEXT);
    localparam int unsigned SZ_IDX = (KIND == BK_M64HI) ? PI : i;
    localparam int unsigned LG   = SIZE_CFG[SZ_IDX*6 +: 6];
    localparam int unsigned NBIT = HIBITS_CFG[i*6 +: 6];
    localparam logic [31:0] WM   = wr_mask(KIND, LG, NBIT);
    localparam logic [31:0] TB   = type_bits(KIND, PREF_CFG[i]);
    localparam logic [31:0] HCMP = hi_cmp_mask(LG);

    assign bar_wr[i] = cfg_wr && (cfg_idx == IDX_W'(i));

    bar_reg #(
      .WMASK(WM), .TBITS(TB), .FIXED(FIX_CFG[i]),
      .FIX_BASE(FIX_BASE_CFG[i*32 +: 32])
    ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(bar_wr[i]), .be(cfg_be),
      .wdata(cfg_wdata), .base(bar_base[i]), .word(bar_word[i])
    );

    bar_match #(.KIND(KIND), .LO_CMP(WM), .HI_CMP(HCMP)) u_match (
      .addr(txn_addr), .is_io(txn_io), .base_lo(bar_base[i]),
      .base_hi(bar_base[i+1]), .hit(bar_hit[i])
    );

    assign bar_word_flat[i*32 +: 32] = bar_word[i];
  end

  always_comb begin
    cfg_rdata = 32'h0;
    for (int i = 0; i < NUM_BARS; i++)
      if (cfg_idx == IDX_W'(i)) cfg_rdata = bar_word[i];
  end
endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk #(
  parameter int unsigned NUM_BARS = 6,
  parameter logic [NUM_BARS*3-1:0] KIND_CFG = '0,
  parameter logic [NUM_BARS-1:0]   FIX_CFG  = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   txn_io,
  input logic [NUM_BARS-1:0]    bar_wr,
  input logic [NUM_BARS-1:0]    bar_hit,
  input logic [NUM_BARS*32-1:0] bar_word_flat
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_wr)); // R12

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk
    localparam logic [2:0] K = KIND_CFG[i*3 +: 3];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bar_wr[i] |=> $stable(bar_word_flat[i*32 +: 32])); // R12

    if (FIX_CFG[i]) begin : g_fix
      AST_FIXED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bar_wr[i] |=> $stable(bar_word_flat[i*32 +: 32])); // R10
    end

    if (K == 3'd2) begin : g_io
      AST_IO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        bar_word_flat[i*32 +: 2] == 2'b01); // R3
      AST_IO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        bar_hit[i] |-> txn_io); // R8
    end

    if (K == 3'd1) begin : g_mem
      AST_MEM_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        bar_hit[i] |-> !txn_io); // R7
      AST_MEM_LOWBIT: assert property (@(posedge clk) disable iff (!rst_n)
        bar_word_flat[i*32 +: 3] == 3'b000); // R2
    end

    if (K == 3'd4 || K == 3'd0) begin : g_silent
      AST_NO_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !bar_hit[i]); // R6
    end
  end
endmodule

bind pci_bar_bank bar_bank_chk #(
  .NUM_BARS(NUM_BARS), .KIND_CFG(KIND_CFG), .FIX_CFG(FIX_CFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_io(txn_io), .bar_wr(bar_wr),
  .bar_hit(bar_hit), .bar_word_flat(bar_word_flat)
);

// File: tb/tb_pci_bar_bank.sv
module tb_pci_bar_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [63:0] txn_addr = 64'h0;
  logic        txn_io = 1'b0;
  logic [5:0]  bar_hit;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // slot0 mem32 4KB, slots1/2 64-bit 1MB pref N=8, slot3 io 32B,
  // slot4 mem32 64KB fixed at C0DE0000, slot5 unused
  pci_bar_bank #(
    .NUM_BARS(6),
    .KIND_CFG({3'd0, 3'd1, 3'd2, 3'd4, 3'd3, 3'd1}),
    .SIZE_CFG({6'd0, 6'd16, 6'd5, 6'd0, 6'd20, 6'd12}),
    .HIBITS_CFG({6'd32, 6'd32, 6'd32, 6'd8, 6'd32, 6'd32}),
    .PREF_CFG(6'b000010),
    .FIX_CFG(6'b010000),
    .FIX_BASE_CFG({32'h0, 32'hC0DE_0000, 32'h0, 32'h0, 32'h0, 32'h0})
  ) dut (.*);

  // Expected readback after an all-ones write: ones from bit lg up, plus type.
  function automatic logic [31:0] sized(int lg, logic [31:0] tb);
    logic [31:0] v = 32'h0;
    for (int b = lg; b < 32; b++) v[b] = 1'b1;
    return v | tb;
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_chk(string req, logic [2:0] idx, logic [31:0] exp);
    cfg_idx = idx;
    #1;
    check32(req, cfg_rdata, exp);
  endtask

  task automatic hit_chk(string req, logic [63:0] a, logic io, logic [5:0] exp);
    txn_addr = a; txn_io = io;
    #1;
    check32(req, {26'h0, bar_hit}, {26'h0, exp});
  endtask

  task automatic t_reset;
    read_chk("R1 slot0", 3'd0, 32'h0);
    read_chk("R2 slot1 type", 3'd1, 32'h0000_000C);
    read_chk("R1 slot2", 3'd2, 32'h0);
    read_chk("R3 slot3 io", 3'd3, 32'h1);
    read_chk("R10 slot4 fixed", 3'd4, 32'hC0DE_0000);
    read_chk("R11 slot5", 3'd5, 32'h0);
    read_chk("R1 idx6", 3'd6, 32'h0);
    read_chk("R1 idx7", 3'd7, 32'h0);
    hit_chk("R10 fixed claim", 64'hC0DE_1234, 1'b0, 6'b010000);
    hit_chk("R7 R9 base zero", 64'h100, 1'b0, 6'b000011);
  endtask

  task automatic t_sizing;
    for (int i = 0; i < 6; i++) cfg_write(3'(i), 4'hF, 32'hFFFF_FFFF);
    read_chk("R4 slot0", 3'd0, sized(12, 32'h0));
    read_chk("R4 slot1", 3'd1, sized(20, 32'hC));
    read_chk("R6 slot2 upper", 3'd2, 32'h0000_00FF);
    read_chk("R3 R4 slot3", 3'd3, sized(5, 32'h1));
    read_chk("R10 slot4 write ignored", 3'd4, 32'hC0DE_0000);
    read_chk("R11 slot5", 3'd5, 32'h0);
  endtask

  task automatic t_bytes;
    cfg_write(3'd0, 4'hF, 32'h0);
    cfg_write(3'd0, 4'b0100, 32'h1234_5678);
    read_chk("R5 byte2", 3'd0, 32'h0034_0000);
    cfg_write(3'd0, 4'b1001, 32'hAB00_00CD);
    read_chk("R5 bytes3,0", 3'd0, 32'hAB34_0000);
    @(negedge clk);
    cfg_idx = 3'd0; cfg_wdata = 32'h5555_5555; cfg_be = 4'hF; cfg_wr = 1'b0;
    @(negedge clk);
    read_chk("R12 no strobe", 3'd0, 32'hAB34_0000);
  endtask

  task automatic t_decode;
    cfg_write(3'd0, 4'hF, 32'h8000_0000);
    cfg_write(3'd1, 4'hF, 32'h0010_0000);
    cfg_write(3'd2, 4'hF, 32'hFFFF_FF42);
    read_chk("R6 upper masked", 3'd2, 32'h0000_0042);
    cfg_write(3'd3, 4'hF, 32'h0000_C020);
    read_chk("R3 io base", 3'd3, 32'h0000_C021);
    hit_chk("R7 in window", 64'h8000_0ABC, 1'b0, 6'b000001);
    hit_chk("R7 io space", 64'h8000_0ABC, 1'b1, 6'b000000);
    hit_chk("R7 past end", 64'h8000_1000, 1'b0, 6'b000000);
    hit_chk("R7 upper set", 64'h1_8000_0000, 1'b0, 6'b000000);
    hit_chk("R9 pair top", 64'h42_001F_FFFF, 1'b0, 6'b000010);
    hit_chk("R9 pair past end", 64'h42_0020_0000, 1'b0, 6'b000000);
    hit_chk("R9 upper differs", 64'h142_0010_0000, 1'b0, 6'b000000);
    hit_chk("R8 io top", 64'hC03F, 1'b1, 6'b001000);
    hit_chk("R8 io past end", 64'hC040, 1'b1, 6'b000000);
    hit_chk("R8 mem space", 64'hC03F, 1'b0, 6'b000000);
    hit_chk("R10 fixed still claims", 64'hC0DE_FFFF, 1'b0, 6'b010000);
    hit_chk("R11 unused zero addr", 64'h0, 1'b0, 6'b000000);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizing();
    t_bytes();
    t_decode();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog: got running expected done");
      finish_run();
    end
  end
endmodule